// File: doc/BRIEF.md
# Segment Address Translation Unit

This unit sits beside one processor core. It turns a 32-bit logical address into a 36-bit physical address and checks that the access is allowed. Sixteen programmable segment descriptors describe the mapping. Each descriptor names a power-of-two window of the logical space, a replacement base in the wider physical space, and six permission bits. Three of the permission bits apply to supervisor mode and three to user mode, one each for read, write and execute.

Software loads the descriptors through a plain write port that carries a word index and 32 bits of data. The core presents lookups on a separate port. Each lookup carries an address, an access kind and a privilege flag. One cycle later the unit returns the translated address, a hit flag and a fault flag. When several descriptors cover the same address, the one with the highest index decides the result.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset, out_valid, out_hit and out_fault are low and every descriptor is disabled, so any lookup misses (hit and fault both low, out_paddr zero).
- R2: The write port addresses 32-bit words. Descriptor N has its lower word at word index 2N and its upper word at 2N+1, which are byte offsets N*8 and N*8+4. In the lower word, bits 4:0 hold the size code, bits 11:5 are reserved and ignored, and bits 31:12 hold the logical base. In the upper word, bits 7:0 hold the permission byte and bits 31:8 hold the 24-bit replacement base.
- R3: A size code C selects a segment of 2^(C+1) bytes. Code 0x0B is 4 KB, 0x13 is 1 MB, 0x1D is 1 GB and 0x1F is 4 GB. A code below 0x0B disables the descriptor, and a disabled descriptor never matches.
- R4: A segment of 2^N bytes matches when logical address bits 31:N equal the same bits of its logical base. The lower base bits are ignored, so a 4 GB segment matches every address.
- R5: On a hit, physical bits 35:N come from the replacement base (base bit k drives physical bit 12+k). Physical bits N-1:0 equal the logical address bits, and physical bits 35:32 are zero whenever N exceeds them.
- R6: Permission byte bits 5..0 are supervisor read, supervisor write, supervisor execute, user read, user write and user execute. Bits 7:6 are ignored. lk_kind encodes 0 as read, 1 as write and 2 as execute. Kind 3 is granted by no bit. lk_super=1 selects the supervisor bits.
- R7: A lookup that matches but lacks the required permission gives out_fault=1 and out_hit=0. A lookup that matches nothing gives both flags low. out_paddr is zero whenever out_hit is low.
- R8: When several enabled descriptors match, the highest-numbered one alone decides the translation and the permission, even if that result is a fault.
- R9: Results appear one cycle after lk_valid is sampled, with out_valid high in that cycle only. A cycle without lk_valid gives out_valid, out_hit and out_fault low.
- R10: A descriptor write in the same cycle as a lookup takes effect only for later lookups. The concurrent lookup sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Descriptor word write strobe |
| cfg_addr | input | 5 | Word index: descriptor in bits 4:1, upper word when bit 0 is 1 |
| cfg_wdata | input | 32 | Descriptor word data |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Logical address |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| lk_super | input | 1 | 1 for supervisor mode, 0 for user mode |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_paddr | output | 36 | Physical address, zero unless out_hit |
| out_hit | output | 1 | Lookup matched and was permitted |
| out_fault | output | 1 | Lookup matched but was not permitted |

## Verification
A wrongly stored size code or base shows up on the very next lookup into that window. It appears either as a miss where a hit belongs or as a physical address whose boundary between replaced and passed-through bits sits in the wrong place. A swapped permission bit or a broken priority chain changes the hit and fault flags in the single result cycle that follows the request. The directed cases therefore probe each window at its edges, under both modes and all access kinds, and with overlapping segments.

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit #(
  parameter int NSEG = 16,
  parameter int LA_W = 32,
  parameter int PA_W = 36,
  parameter int PG   = 12,
  localparam int IW   = $clog2(NSEG) + 1,
  localparam int LB_W = LA_W - PG,
  localparam int RB_W = PA_W - PG,
  localparam int MIN_CODE = PG - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [IW-1:0]   cfg_addr,
  input  logic [31:0]     cfg_wdata,
  input  logic            lk_valid,
  input  logic [LA_W-1:0] lk_addr,
  input  logic [1:0]      lk_kind,
  input  logic            lk_super,
  output logic            out_valid,
  output logic [PA_W-1:0] out_paddr,
  output logic            out_hit,
  output logic            out_fault
);

  logic [4:0]      code_q  [NSEG];
  logic [LB_W-1:0] lbase_q [NSEG];
  logic [5:0]      perm_q  [NSEG];
  logic [RB_W-1:0] rbase_q [NSEG];

  logic unused_rsv;
  assign unused_rsv = ^cfg_wdata[11:5];

  wire [IW-2:0] widx = cfg_addr[IW-1:1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSEG; i++) begin
        code_q[i]  <= '0;
        lbase_q[i] <= '0;
        perm_q[i]  <= '0;
        rbase_q[i] <= '0;
      end
    end else if (cfg_we) begin
      if (cfg_addr[0]) begin
        perm_q[widx]  <= cfg_wdata[5:0];
        rbase_q[widx] <= cfg_wdata[31:8];
      end else begin
        code_q[widx]  <= cfg_wdata[4:0];
        lbase_q[widx] <= cfg_wdata[31:LA_W-LB_W];
      end
    end
  end

  logic            found;
  logic [5:0]      sel_perm;
  logic [RB_W-1:0] sel_pa;

  always_comb begin
    found    = 1'b0;
    sel_perm = '0;
    sel_pa   = '0;
    for (int i = 0; i < NSEG; i++) begin
      int n;
      logic m;
      logic [RB_W-1:0] pa;
      n = int'(code_q[i]) + 1;
      m = (int'(code_q[i]) >= MIN_CODE);
      for (int j = 0; j < LB_W; j++)
        if (PG + j >= n && lk_addr[PG+j] != lbase_q[i][j]) m = 1'b0;
      for (int j = 0; j < RB_W; j++) begin
        if (PG + j >= n)    pa[j] = rbase_q[i][j];
        else if (j < LB_W)  pa[j] = lk_addr[PG+j];
        else                pa[j] = 1'b0;
      end
      if (m) begin
        found    = 1'b1;
        sel_perm = perm_q[i];
        sel_pa   = pa;
      end
    end
  end

  logic allowed;
  always_comb begin
    case (lk_kind)
      2'd0:    allowed = lk_super ? sel_perm[5] : sel_perm[2];
      2'd1:    allowed = lk_super ? sel_perm[4] : sel_perm[1];
      2'd2:    allowed = lk_super ? sel_perm[3] : sel_perm[0];
      default: allowed = 1'b0;
    endcase
  end

  wire hit_d = lk_valid && found && allowed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_fault <= 1'b0;
      out_paddr <= '0;
    end else begin
      out_valid <= lk_valid;
      out_hit   <= hit_d;
      out_fault <= lk_valid && found && !allowed;
      out_paddr <= hit_d ? {sel_pa, lk_addr[PG-1:0]} : '0;
    end
  end

endmodule

module seg_xlate_unit_chk #(
  parameter int PA_W = 36,
  parameter int PG   = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PG-1:0]   lk_low,
  input logic            out_valid,
  input logic [PA_W-1:0] out_paddr,
  input logic            out_hit,
  input logic            out_fault
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R7
  hit_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_hit && out_fault));

  // R9
  flags_need_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_hit || out_fault) |-> out_valid);

  // R5
  low_bits_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && out_hit) |-> out_paddr[PG-1:0] == $past(lk_low));

  // R7
  paddr_zero_on_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_hit |-> out_paddr == '0);
endmodule

bind seg_xlate_unit seg_xlate_unit_chk #(.PA_W(PA_W), .PG(PG)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_low(lk_addr[PG-1:0]),
  .out_valid(out_valid), .out_paddr(out_paddr),
  .out_hit(out_hit), .out_fault(out_fault)
);

// File: tb/sim_seg_xlate_unit.sv
`timescale 1ns/1ps
module sim_seg_xlate_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [4:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic        lk_valid = 0;
  logic [31:0] lk_addr = 0;
  logic [1:0]  lk_kind = 0;
  logic        lk_super = 0;
  logic        out_valid;
  logic [35:0] out_paddr;
  logic        out_hit;
  logic        out_fault;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  seg_xlate_unit u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_kind(lk_kind), .lk_super(lk_super), .out_valid(out_valid),
    .out_paddr(out_paddr), .out_hit(out_hit), .out_fault(out_fault)
  );

  task automatic check(input string req, input logic v, input logic h,
                       input logic f, input logic [35:0] pa);
    checks++;
    if (out_valid !== v || out_hit !== h || out_fault !== f || out_paddr !== pa) begin
      errors++;
      $display("FAIL %s: got v=%b h=%b f=%b pa=%h, expected v=%b h=%b f=%b pa=%h",
               req, out_valid, out_hit, out_fault, out_paddr, v, h, f, pa);
    end
  endtask

  task automatic wr(input int seg, input bit upper, input logic [31:0] d);
    cfg_we = 1; cfg_addr = 5'(seg * 2 + int'(upper)); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic look(input string req, input logic [31:0] a, input logic [1:0] k,
                      input logic s, input logic h, input logic f,
                      input logic [35:0] pa);
    lk_valid = 1; lk_addr = a; lk_kind = k; lk_super = s;
    @(negedge clk);
    lk_valid = 0;
    check(req, 1'b1, h, f, pa);
  endtask

  task automatic t_reset;
    check("R1 reset outputs", 1'b0, 1'b0, 1'b0, 36'h0);
    look("R1 lookup after reset misses", 32'hE001_2345, 2'd0, 1'b1, 1'b0, 1'b0, 36'h0);
  endtask

  task automatic t_one_mb;
    wr(3, 1'b0, 32'hE000_0FF3);
    wr(3, 1'b1, 32'h00C0_00F6);
    look("R5 1MB supervisor read", 32'hE001_2345, 2'd0, 1'b1, 1'b1, 1'b0, 36'h0_0C01_2345);
    look("R6 1MB user write", 32'hE00F_FFFF, 2'd1, 1'b0, 1'b1, 1'b0, 36'h0_0C0F_FFFF);
    look("R6 1MB user execute faults", 32'hE000_0010, 2'd2, 1'b0, 1'b0, 1'b1, 36'h0);
    look("R6 1MB supervisor execute faults", 32'hE000_0010, 2'd2, 1'b1, 1'b0, 1'b1, 36'h0);
    look("R4 just above 1MB misses", 32'hE010_0000, 2'd0, 1'b1, 1'b0, 1'b0, 36'h0);
    @(negedge clk);
    check("R9 idle cycle gives no result", 1'b0, 1'b0, 1'b0, 36'h0);
  endtask

  task automatic t_one_gb;
    wr(1, 1'b0, 32'h8000_001D);
    wr(1, 1'b1, 32'h1C00_003F);
    look("R5 1GB top of window", 32'hBFFF_FFF0, 2'd2, 1'b0, 1'b1, 1'b0, 36'h1_FFFF_FFF0);
    look("R4 1GB bottom of window", 32'h8000_0000, 2'd1, 1'b1, 1'b1, 1'b0, 36'h1_C000_0000);
    look("R4 1GB outside misses", 32'hC000_0000, 2'd0, 1'b1, 1'b0, 1'b0, 36'h0);
    look("R6 reserved kind faults", 32'h9000_0000, 2'd3, 1'b1, 1'b0, 1'b1, 36'h0);
  endtask

  task automatic t_priority;
    wr(5, 1'b0, 32'hE001_200B);
    wr(5, 1'b1, 32'h0007_773F);
    look("R8 4KB seg5 over seg3", 32'hE001_2ABC, 2'd0, 1'b0, 1'b1, 1'b0, 36'h0_0077_7ABC);
    look("R8 next page back to seg3", 32'hE001_3000, 2'd0, 1'b0, 1'b1, 1'b0, 36'h0_0C01_3000);
    wr(7, 1'b0, 32'hE001_200B);
    wr(7, 1'b1, 32'hFFFF_FFC0);
    look("R8 higher seg without permission faults", 32'hE001_2ABC, 2'd0, 1'b1, 1'b0, 1'b1, 36'h0);
    wr(7, 1'b0, 32'hE001_200A);
    look("R3 code 0x0A disables seg7", 32'hE001_2ABC, 2'd0, 1'b1, 1'b1, 1'b0, 36'h0_0077_7ABC);
  endtask

  task automatic t_four_gb;
    wr(15, 1'b1, 32'hF000_0004);
    wr(15, 1'b0, 32'h0000_001F);
    look("R3 4GB user read", 32'h1234_5678, 2'd0, 1'b0, 1'b1, 1'b0, 36'hF_1234_5678);
    look("R6 4GB supervisor read faults", 32'hE001_2ABC, 2'd0, 1'b1, 1'b0, 1'b1, 36'h0);
    wr(15, 1'b0, 32'h0000_0000);
    look("R3 code 0 disables seg15", 32'h1234_5678, 2'd0, 1'b0, 1'b0, 1'b0, 36'h0);
  endtask

  task automatic t_same_cycle;
    cfg_we = 1; cfg_addr = 5'd30; cfg_wdata = 32'h0000_001F;
    lk_valid = 1; lk_addr = 32'h4000_0000; lk_kind = 2'd0; lk_super = 1'b0;
    @(negedge clk);
    cfg_we = 0; lk_valid = 0;
    check("R10 concurrent lookup sees old descriptor", 1'b1, 1'b0, 1'b0, 36'h0);
    look("R10 later lookup sees new descriptor", 32'h4000_0000, 2'd0, 1'b0, 1'b1, 1'b0, 36'hF_4000_0000);
    wr(15, 1'b1, 32'h0000_0000);
    look("R2 upper word rewrite clears permission", 32'h4000_0000, 2'd0, 1'b0, 1'b0, 1'b1, 36'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_one_mb();
    t_one_gb();
    t_priority();
    t_four_gb();
    t_same_cycle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: got hang, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule